// File: doc/BRIEF.md
# Reloadable Down-Counter PWM Timer

This block is an 8-bit down counter that reloads itself and drives a pulse-width modulated output. A separate prescaler supplies a count-enable tick. On each tick, while the run bit is set, the counter steps down by one. When a tick arrives with the counter at zero, the counter takes the reload value and emits an underflow pulse. The reload value therefore sets the period, which is reload+1 ticks.

When the PWM-mode bit is set, each new counter value is compared with the compare register. On a match the block emits an interrupt pulse and drives the output low. An underflow drives the output high. The output is high for reload−compare ticks and low for compare+1 ticks of each period. This holds when reload > compare and compare ≠ 0. When reload ≤ compare, the output goes high at the first underflow and stays high.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset `pwm_out`, `cmp_irq` and `uf_pulse` are 0 and the internal count is 0, so the first counted tick underflows.
- R2: A tick counted (`run`=1, `tick`=1) while the count is 0 loads `reload` into the count and raises `uf_pulse` for exactly the next clock cycle.
- R3: A tick counted while the count is nonzero decrements it by one, so underflow pulses recur every `reload`+1 counted ticks.
- R4: With `pwm_en`=1, a counted tick whose new count value equals `compare` raises `cmp_irq` for the next clock cycle. The new count value is `reload` after an underflow, otherwise the old count minus one.
- R5: With `pwm_en`=1, `pwm_out` goes to 1 on an underflow and goes to 0 on a compare match.
- R6: When underflow and compare match happen on the same counted tick, `pwm_out` becomes 1. This case arises with `reload` = `compare`.
- R7: With `reload` ≤ `compare`, `pwm_out` stays 1 from the first underflow onward.
- R8: While `run`=0, the count and `pwm_out` hold their values and no `uf_pulse` or `cmp_irq` is produced.
- R9: With `pwm_en`=0, `pwm_out` is held at 0 and `cmp_irq` stays 0, while counting and `uf_pulse` continue.
- R10: A clock cycle with `tick`=0 changes neither the count nor `pwm_out`, and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Count enable from prescaler |
| run | input | 1 | Counter run control |
| pwm_en | input | 1 | PWM mode select |
| reload | input | 8 | Reload (period) value |
| compare | input | 8 | Compare (duty) value |
| pwm_out | output | 1 | PWM waveform |
| cmp_irq | output | 1 | One-cycle compare-match interrupt pulse |
| uf_pulse | output | 1 | One-cycle underflow pulse |

## Verification
All three outputs are registered. Each one reflects the tick sampled at a clock edge for the whole clock cycle that follows that edge. The bench drives inputs on the falling edge and advances its reference model just after the rising edge. It compares all three outputs on the next falling edge, exactly one cycle after the stimulus. Random ticks, run and mode changes, and small reload/compare values exercise the period and duty paths. Directed phases force equal reload and compare, reload below compare, stopped runs and mode off.

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         pwm_en,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] compare,
  output logic         pwm_out,
  output logic         cmp_irq,
  output logic         uf_pulse
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] next_val;
  logic         step, uf_hit, cm_hit;
  logic         pwm_q, irq_q, uf_q;

  assign step     = run & tick;
  assign next_val = (cnt_q == '0) ? reload : cnt_q - 1'b1;
  assign uf_hit   = step & (cnt_q == '0);
  assign cm_hit   = step & pwm_en & (next_val == compare);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      uf_q  <= 1'b0;
      irq_q <= 1'b0;
      pwm_q <= 1'b0;
    end else begin
      if (step) cnt_q <= next_val;
      uf_q  <= uf_hit;
      irq_q <= cm_hit;
      if (!pwm_en)     pwm_q <= 1'b0;
      else if (uf_hit) pwm_q <= 1'b1;
      else if (cm_hit) pwm_q <= 1'b0;
    end
  end

  assign pwm_out  = pwm_q;
  assign cmp_irq  = irq_q;
  assign uf_pulse = uf_q;

  // R2: an underflow pulse only follows a counted tick
  a_r2_uf_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    uf_pulse |-> $past(tick && run));

  // R4: compare interrupt only in PWM mode after a counted tick
  a_r4_irq_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> $past(pwm_en && run && tick));

  // R6: underflow in PWM mode leaves the output high
  a_r6_uf_sets_out: assert property (@(posedge clk) disable iff (!rst_n)
    (uf_pulse && $past(pwm_en)) |-> pwm_out);

  // R8: stopped timer holds output and makes no pulses
  a_r8_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(run) && $past(pwm_en)) |-> ($stable(pwm_out) && !uf_pulse && !cmp_irq));

  // R9: mode off forces output low
  a_r9_mode_off: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pwm_en) |-> (!pwm_out && !cmp_irq));

endmodule

// File: tb/pwm_reload_timer_tb.sv
module pwm_reload_timer_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, run = 1'b0, pwm_en = 1'b0;
  logic [7:0] reload = 8'd0, compare = 8'd0;
  logic pwm_out, cmp_irq, uf_pulse;

  int checks = 0, errors = 0;
  logic [7:0] m_cnt;
  logic m_pwm, m_irq, m_uf;

  always #4 clk = ~clk;

  pwm_reload_timer #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .pwm_en(pwm_en),
    .reload(reload), .compare(compare),
    .pwm_out(pwm_out), .cmp_irq(cmp_irq), .uf_pulse(uf_pulse));

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] nxt(logic [7:0] c, logic [7:0] r);
    return (c == 8'd0) ? r : c - 8'd1;
  endfunction

  task automatic step(string tag, logic t, logic rn, logic pe);
    logic [7:0] nv;
    logic u, m;
    tick = t; run = rn; pwm_en = pe;
    @(posedge clk);
    #1;
    nv = nxt(m_cnt, reload);
    u  = t && rn && (m_cnt == 8'd0);
    m  = t && rn && pe && (nv == compare);
    if (t && rn) m_cnt = nv;
    m_uf = u; m_irq = m;
    if (!pe) m_pwm = 1'b0;
    else if (u) m_pwm = 1'b1;
    else if (m) m_pwm = 1'b0;
    @(negedge clk);
    chk(tag, "uf_pulse", uf_pulse, m_uf);
    chk(tag, "cmp_irq", cmp_irq, m_irq);
    chk(tag, "pwm_out", pwm_out, m_pwm);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_cnt = 0; m_pwm = 0; m_irq = 0; m_uf = 0;
    repeat (3) @(negedge clk);
    chk("R1", "pwm_out", pwm_out, 1'b0);
    chk("R1", "cmp_irq", cmp_irq, 1'b0);
    chk("R1", "uf_pulse", uf_pulse, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1/R2/R5: first tick underflows, reload 5 compare 2
    reload = 8'd5; compare = 8'd2;
    step("R2", 1, 1, 1);
    chk("R2", "first tick underflow", uf_pulse, 1'b1);
    chk("R5", "high after underflow", pwm_out, 1'b1);
    // R3/R4/R5: walk a full period
    for (int i = 0; i < 12; i++) step("R3", 1, 1, 1);
    // R10: idle cycles without tick
    for (int i = 0; i < 4; i++) step("R10", 0, 1, 1);
    // R8: stopped with ticks
    for (int i = 0; i < 5; i++) step("R8", 1, 0, 1);
    // R6: reload equals compare
    reload = 8'd3; compare = 8'd3;
    for (int i = 0; i < 10; i++) step("R6", 1, 1, 1);
    // R7: reload below compare, output sticks high
    reload = 8'd2; compare = 8'd6;
    for (int i = 0; i < 10; i++) begin
      step("R7", 1, 1, 1);
      if (i > 3) chk("R7", "sticky high", pwm_out, 1'b1);
    end
    // R9: mode off
    reload = 8'd4; compare = 8'd1;
    for (int i = 0; i < 10; i++) begin
      step("R9", 1, 1, 0);
      chk("R9", "output low", pwm_out, 1'b0);
    end
    // R4: compare zero
    reload = 8'd3; compare = 8'd0;
    for (int i = 0; i < 10; i++) step("R4", 1, 1, 1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 40) == 0) begin
        reload  = 8'($urandom_range(0, 12));
        compare = 8'($urandom_range(0, 12));
      end
      step("R5", ($urandom_range(0, 9) < 7), ($urandom_range(0, 9) < 9),
           ($urandom_range(0, 19) != 0));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule